// File: doc/BRIEF.md
# Serial Flash Write-Enable Controller

This block is the instruction front end of a serial flash device for the commands that change what the device may do. While chip select is low it collects an opcode from the data pins. Each valid serial clock edge shifts in one bit in single-bit mode, or four bits in quad mode. When chip select returns high, the block decodes the opcode. Depending on the opcode it sets or clears the write-enable latch, enters or leaves one-time-programmable mode, or switches opcode entry to quad mode.

Program, erase and status-write opcodes only pass when the latch is set. When one passes, the block sends a one-cycle start strobe, together with the opcode, to the array sequencer. The sequencer returns a completion pulse, which clears the latch. The whole block runs on one system clock. The serial clock reaches it as a synchronised rising-edge strobe, and chip select is sampled on the same clock.

Top module: `flash_wren_ctrl`

## Requirements
- R1: After reset, the latch, the one-time-programmable flag, the quad flag and the start strobe are all 0.
- R2: In single-bit mode, each `sck_rise` cycle with `cs_n` low shifts in `sdat[0]`, most significant bit first. A rising `cs_n` seen on `clk` decodes the opcode at that edge.
- R3: Opcode 0x06 sets `wel`.
- R4: Opcode 0x04 clears `wel` and also clears `otp_mode`.
- R5: Opcode 0x3A sets `otp_mode`.
- R6: Opcode 0x38 sets `quad_mode`, and only reset clears it. In quad mode each `sck_rise` shifts in `sdat[3:0]` with `sdat[3]` as the most significant bit, so an opcode takes two strobes.
- R7: An instruction whose shifted bit count is not exactly 8 changes no output.
- R8: When `wel` is 1, the modifying opcodes are accepted: 0x02, 0x20, 0x52, 0xD8, 0xC7, 0x60 and 0x01. An accepted opcode raises `mod_start` for exactly one cycle, in the cycle after the decoding edge, with `mod_op` equal to the opcode. `wel` stays set.
- R9: A modifying opcode that arrives while `wel` is 0 raises no `mod_start`.
- R10: `done_pulse` clears `wel`. If the same edge also decodes 0x06, `wel` ends up set.
- R11: Any other opcode changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| sdat | input | 4 | Data pins; only bit 0 is used in single-bit mode |
| done_pulse | input | 1 | Completion pulse from the array sequencer |
| wel | output | 1 | Write-enable latch |
| otp_mode | output | 1 | One-time-programmable mode flag |
| quad_mode | output | 1 | Quad opcode entry is active |
| mod_start | output | 1 | Start strobe to the array sequencer |
| mod_op | output | 8 | Opcode of the accepted modifying command |

## Verification
The assertions check several properties on every cycle:
- a start strobe is never raised without a set latch;
- the start strobe lasts one cycle;
- the quad flag never falls;
- the latch only rises at an instruction end;
- a lone completion pulse clears the latch.

The bench's scenarios are what show the rest. They cover the exact opcode decoding, the bit-order and nibble-order rules in both modes, and the rejection of 7-, 9-, 4- and 12-bit frames. They also cover the same-edge race between completion and set, and the silence that follows unrecognised opcodes.

// File: rtl/flash_wren_ctrl.sv
module flash_wren_ctrl #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sck_rise,
  input  logic [3:0]     sdat,
  input  logic           done_pulse,
  output logic           wel,
  output logic           otp_mode,
  output logic           quad_mode,
  output logic           mod_start,
  output logic [OPW-1:0] mod_op
);
  localparam int CW = $clog2(OPW) + 2;
  localparam logic [OPW-1:0] OP_SET   = OPW'(8'h06);
  localparam logic [OPW-1:0] OP_CLR   = OPW'(8'h04);
  localparam logic [OPW-1:0] OP_QUAD  = OPW'(8'h38);
  localparam logic [OPW-1:0] OP_OTP   = OPW'(8'h3A);

  logic           cs_q;
  logic [OPW-1:0] sr;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  step;
  logic           cs_rise;
  logic           frame_ok;

  assign step     = quad_mode ? CW'(4) : CW'(1);
  assign cs_rise  = cs_n & ~cs_q;
  assign frame_ok = cs_rise && (cnt == CW'(OPW));

  function automatic logic is_mod(input logic [OPW-1:0] op);
    case (op)
      OPW'(8'h02), OPW'(8'h20), OPW'(8'h52), OPW'(8'hD8),
      OPW'(8'hC7), OPW'(8'h60), OPW'(8'h01): is_mod = 1'b1;
      default: is_mod = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      sr        <= '0;
      cnt       <= '0;
      wel       <= 1'b0;
      otp_mode  <= 1'b0;
      quad_mode <= 1'b0;
      mod_start <= 1'b0;
      mod_op    <= '0;
    end else begin
      cs_q      <= cs_n;
      mod_start <= 1'b0;
      if (cs_n) cnt <= '0;
      else if (sck_rise) begin
        sr <= quad_mode ? {sr[OPW-5:0], sdat} : {sr[OPW-2:0], sdat[0]};
        if (cnt < CW'(OPW + 4)) cnt <= cnt + step;
      end
      if (done_pulse) wel <= 1'b0;
      if (frame_ok) begin
        if (sr == OP_SET) wel <= 1'b1;
        else if (sr == OP_CLR) begin
          wel      <= 1'b0;
          otp_mode <= 1'b0;
        end else if (sr == OP_QUAD) quad_mode <= 1'b1;
        else if (sr == OP_OTP) otp_mode <= 1'b1;
        else if (is_mod(sr) && wel) begin
          mod_start <= 1'b1;
          mod_op    <= sr;
        end
      end
    end
  end

  assert_start_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> $past(wel));
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |=> !mod_start);
  assert_quad_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(quad_mode));
  assert_wel_rise_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !cs_rise) |=> !wel);
endmodule

// File: tb/flash_wren_ctrl_bench.sv
module flash_wren_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, sck_rise = 0, done_pulse = 0;
  logic [3:0] sdat = 0;
  logic wel, otp_mode, quad_mode, mod_start;
  logic [7:0] mod_op;

  int total = 0, bad = 0;
  logic e_wel = 0, e_otp = 0, e_quad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wren_ctrl u_flash_wren_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sdat(sdat),
    .done_pulse(done_pulse), .wel(wel), .otp_mode(otp_mode),
    .quad_mode(quad_mode), .mod_start(mod_start), .mod_op(mod_op));

  function automatic logic is_mod(input logic [7:0] op);
    return op inside {8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h01};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    chk({req, " wel"}, {7'd0, wel}, {7'd0, e_wel});
    chk({req, " otp"}, {7'd0, otp_mode}, {7'd0, e_otp});
    chk({req, " quad"}, {7'd0, quad_mode}, {7'd0, e_quad});
  endtask

  // beats: strobes sent; done_at_end: completion pulse on the same edge as cs rise
  task automatic send(input logic [7:0] op, input int beats, input logic done_at_end,
                      input string req);
    logic ok, exp_start;
    ok = e_quad ? (beats == 2) : (beats == 8);
    exp_start = ok && is_mod(op) && e_wel;
    @(negedge clk) cs_n = 0;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      sck_rise = 1;
      if (e_quad) sdat = (i < 2) ? 4'((op >> (4 - 4*i)) & 8'hF) : 4'h0;
      else        sdat = {3'b0, (i < 8) ? op[7-i] : 1'b0};
    end
    @(negedge clk);
    sck_rise = 0; cs_n = 1; done_pulse = done_at_end;
    if (done_at_end) e_wel = 0;
    if (ok) begin
      if (op == 8'h06) e_wel = 1;
      else if (op == 8'h04) begin e_wel = 0; e_otp = 0; end
      else if (op == 8'h38) e_quad = 1;
      else if (op == 8'h3A) e_otp = 1;
    end
    @(posedge clk); #1;
    done_pulse = 0;
    chk({req, " start"}, {7'd0, mod_start}, {7'd0, exp_start});
    if (exp_start) chk({req, " op"}, mod_op, op);
    check_flags(req);
    @(posedge clk); #1;
    chk({req, " start-once"}, {7'd0, mod_start}, 8'd0);
  endtask

  task automatic pulse_done();
    @(negedge clk) done_pulse = 1;
    @(negedge clk) done_pulse = 0;
    e_wel = 0;
    #1 check_flags("R10 done");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [12];
    int seed_dummy;
    pool = '{8'h06, 8'h04, 8'h3A, 8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h01, 8'h38, 8'h9F};
    seed_dummy = $urandom(1234);
    repeat (3) @(posedge clk);
    #1;
    check_flags("R1 reset");
    chk("R1 start", {7'd0, mod_start}, 8'd0);
    rst_n = 1;
    // R9: modify while latch clear
    send(8'h02, 8, 0, "R9 blocked");
    // R7: wrong counts
    send(8'h06, 7, 0, "R7 seven");
    send(8'h06, 9, 0, "R7 nine");
    // R2/R3
    send(8'h06, 8, 0, "R3 set");
    send(8'hD8, 8, 0, "R8 accept");
    send(8'h9F, 8, 0, "R11 other");
    pulse_done();
    send(8'h06, 8, 0, "R3 set2");
    send(8'h06, 8, 1, "R10 race");
    send(8'h3A, 8, 0, "R5 otp");
    send(8'h04, 8, 0, "R4 clear");
    send(8'h38, 8, 0, "R6 quad");
    send(8'h06, 1, 0, "R7 quad four");
    send(8'h06, 3, 0, "R7 quad twelve");
    send(8'h06, 2, 0, "R6 quad set");
    send(8'hC7, 2, 0, "R8 quad accept");
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op;
      int beats;
      op = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pool[$urandom_range(0, 11)];
      if (e_quad) beats = ($urandom_range(0, 4) == 0) ? (($urandom_range(0, 1) == 1) ? 3 : 1) : 2;
      else        beats = ($urandom_range(0, 4) == 0) ? (($urandom_range(0, 1) == 1) ? 9 : 7) : 8;
      send(op, beats, 0, "R8 random");
      if ($urandom_range(0, 5) == 0) pulse_done();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule